// File: doc/BRIEF.md
# Staggered Channel Gate Sequencer

This block turns a vector of per-channel on/off requests into the gate signals of a bank of current-sink drivers. A channel's gate is raised only while the global active-low output enable is asserted and its request bit is set. Every change on a channel reaches its gate late by a delay that grows linearly with the channel index. Channel 0 takes the shortest path. Each later channel waits one more step of `STEP_CYC` clock cycles. Because the switching edges are spread out in time, the bank never turns on or off all at once, which limits inrush current and ground bounce.

The output enable may be toggled as a PWM signal to dim every channel together. Each channel then reproduces the PWM train with the same pulse width, shifted by its own delay. A thermal kill input works outside this ordering. It forces every gate low in the same cycle, without waiting for a clock edge, and it empties all delay lines. When kill is released, the channels come back one by one in stagger order.

Top module: `staggered_gate_seq`

## Requirements
- R1: While `rst_n` is low, every gate is 0. After reset is released, a gate goes high only once a request for it has passed through its delay.
- R2: Channel 0's gate shows the requested level (`onoff_latch[0]` and not `oe_n`) sampled at the previous rising clock edge. Channel i shows the same request `i*STEP_CYC` cycles later than channel 0 does.
- R3: The graded delay of R2 applies both to rising and to falling gate transitions.
- R4: While `oe_n` is 1, every channel is driven off. The turn-off follows the stagger, and once `oe_n` has been held high for `(NUM_CH-1)*STEP_CYC+1` edges, all gates are 0.
- R5: While `oe_n` is 0 and kill is 0, once the inputs have been steady for the full stagger span, `gate[i]` equals `onoff_latch[i]` (bit i belongs to channel i).
- R6: A low pulse of W cycles on `oe_n` produces, on every enabled channel, a gate pulse of exactly W cycles.
- R7: While `therm_kill` is 1, all gates are 0, in the same cycle as kill rises and without waiting for a clock edge.
- R8: Kill empties every delay line. When kill falls, all gates are still 0. After that they return in stagger order, with channel 0 first, one edge after the release.
- R9: Changing a single request bit moves only that channel's gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the stagger step is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| onoff_latch | input | NUM_CH | Latched per-channel on/off request, bit i for channel i |
| oe_n | input | 1 | Global output enable, active low |
| therm_kill | input | 1 | Thermal kill, forces all gates low immediately |
| gate | output | NUM_CH | Per-channel driver gate, 1 = sinking |

## Verification
The hardest case is the exact edge on which each channel moves after a step change. A chain that is one tap too long or too short would shift a channel by a cycle, and the per-cycle reference model would flag it on the first rising or falling sweep. A kill that waited for the clock would leave gates high for part of a cycle, which the mid-cycle probe detects. A kill that gated the output without flushing the chains would bring every channel back at the same moment on release, instead of channel 0 first. A short PWM pulse on the enable is checked for its width on the first and last channels, which catches delay lines that stretch or swallow pulses.

// File: rtl/sg_pkg.sv
package sg_pkg;
  // Depth of the tap chain feeding channel idx.
  function automatic int unsigned stagger_depth(input int unsigned idx, input int unsigned step);
    return idx * step;
  endfunction

  // Edges needed before the last channel reflects a steady request.
  function automatic int unsigned settle_edges(input int unsigned nch, input int unsigned step);
    return (nch - 1) * step + 1;
  endfunction
endpackage

// File: rtl/sg_req_gen.sv
module sg_req_gen #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic [NUM_CH-1:0] onoff,
  input  logic              oe_n,
  input  logic              kill,
  output logic [NUM_CH-1:0] req_vec,
  output logic              flush
);
  always_comb begin
    req_vec = onoff & {NUM_CH{~oe_n}};
    flush   = kill;
  end
endmodule

// File: rtl/sg_tap_chain.sv
module sg_tap_chain #(
  parameter int unsigned DEPTH = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic din,
  output logic dout
);
  logic [DEPTH:0] taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= '0;
    end else if (flush) begin
      taps <= '0;
    end else begin
      taps[0] <= din;
      for (int k = 1; k <= int'(DEPTH); k++) begin
        taps[k] <= taps[k-1];
      end
    end
  end

  assign dout = taps[DEPTH];
endmodule

// File: rtl/sg_gate_stage.sv
module sg_gate_stage #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic [NUM_CH-1:0] delayed,
  input  logic              kill,
  output logic [NUM_CH-1:0] gate
);
  always_comb gate = delayed & {NUM_CH{~kill}};
endmodule

// File: rtl/staggered_gate_seq.sv
module staggered_gate_seq #(
  parameter int unsigned NUM_CH   = 16,
  parameter int unsigned STEP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] onoff_latch,
  input  logic              oe_n,
  input  logic              therm_kill,
  output logic [NUM_CH-1:0] gate
);
  logic [NUM_CH-1:0] req_vec;
  logic [NUM_CH-1:0] delayed_vec;
  logic              chain_flush;

  sg_req_gen #(.NUM_CH(NUM_CH)) u_req (
    .onoff   (onoff_latch),
    .oe_n    (oe_n),
    .kill    (therm_kill),
    .req_vec (req_vec),
    .flush   (chain_flush)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int unsigned D = sg_pkg::stagger_depth(g, STEP_CYC);
    sg_tap_chain #(.DEPTH(D)) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (chain_flush),
      .din   (req_vec[g]),
      .dout  (delayed_vec[g])
    );
  end

  sg_gate_stage #(.NUM_CH(NUM_CH)) u_out (
    .delayed (delayed_vec),
    .kill    (therm_kill),
    .gate    (gate)
  );
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int unsigned NUM_CH   = 16,
  parameter int unsigned STEP_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oe_n,
  input logic              kill,
  input logic [NUM_CH-1:0] onoff,
  input logic [NUM_CH-1:0] req_vec,
  input logic [NUM_CH-1:0] gate
);
  localparam int unsigned LAT = sg_pkg::settle_edges(NUM_CH, STEP_CYC);
  localparam int unsigned CW  = $clog2(LAT + 1);

  logic          armed;
  logic [CW-1:0] quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      quiet_cnt <= '0;
    end else begin
      armed <= 1'b1;
      if (!(oe_n || kill)) quiet_cnt <= '0;
      else if (quiet_cnt != CW'(LAT)) quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  assert_ch0_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !kill) |-> (gate[0] == $past(req_vec[0] && !kill)));

  assert_oe_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_cnt == CW'(LAT)) |-> (gate == '0));

  assert_kill_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> (gate == '0));

  assert_release_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(kill)) |-> (gate == '0));

  always_comb begin
    if (rst_n && onoff == '0) begin
      assert_no_req_R5: assert (req_vec == '0);
    end
  end
endmodule

bind staggered_gate_seq sg_checker #(.NUM_CH(NUM_CH), .STEP_CYC(STEP_CYC)) u_sg_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .oe_n    (oe_n),
  .kill    (therm_kill),
  .onoff   (onoff_latch),
  .req_vec (req_vec),
  .gate    (gate)
);

// File: tb/test_staggered_gate_seq.sv
`timescale 1ns/1ps
module test_staggered_gate_seq;
  localparam int NCH  = 16;
  localparam int STEP = 4;
  localparam int HD   = (NCH - 1) * STEP + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  onoff = '1;
  logic            oe_n = 1'b0;
  logic            kill = 1'b0;
  logic [NCH-1:0]  gate;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  staggered_gate_seq #(.NUM_CH(NCH), .STEP_CYC(STEP)) i_staggered_gate_seq (
    .clk(clk), .rst_n(rst_n), .onoff_latch(onoff), .oe_n(oe_n),
    .therm_kill(kill), .gate(gate)
  );

  // Reference: history of requested levels, newest at index 0, emptied by kill.
  logic [NCH-1:0] hist [HD];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < HD; k++) hist[k] <= '0;
    end else if (kill) begin
      for (int k = 0; k < HD; k++) hist[k] <= '0;
    end else begin
      hist[0] <= onoff & {NCH{~oe_n}};
      for (int k = 1; k < HD; k++) hist[k] <= hist[k-1];
    end
  end

  task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gate=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle model compare (R2, R3, R6).
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic [NCH-1:0] e;
      for (int i = 0; i < NCH; i++) e[i] = hist[i*STEP][i] & ~kill;
      check("R2/R3 per-cycle model", gate, e);
    end
  end

  // {onoff, oe_n, kill, expected}
  localparam logic [33:0] VEC [8] = '{
    {16'hA5C3, 1'b0, 1'b0, 16'hA5C3},
    {16'hA5C3, 1'b1, 1'b0, 16'h0000},
    {16'hFFFF, 1'b0, 1'b0, 16'hFFFF},
    {16'hFFFF, 1'b0, 1'b1, 16'h0000},
    {16'h0001, 1'b0, 1'b0, 16'h0001},
    {16'h8000, 1'b0, 1'b0, 16'h8000},
    {16'h5A5A, 1'b1, 1'b1, 16'h0000},
    {16'h0000, 1'b0, 1'b0, 16'h0000}
  };

  task automatic edge_wait(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  initial begin
    int cnt0, cnt15;
    logic [NCH-1:0] e;
    // R1: reset holds all gates dark even with requests active
    edge_wait(5);
    check("R1 reset", gate, '0);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1 post-release before edge", gate, '0);

    // Table walk: R4, R5, R7, R9
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      onoff = VEC[v][33:18]; oe_n = VEC[v][17]; kill = VEC[v][16];
      edge_wait(HD + 2);
      check($sformatf("R4/R5/R7/R9 vector %0d", v), gate, VEC[v][15:0]);
    end

    // R2 rising sweep from all-off
    @(negedge clk); kill = 0; oe_n = 0; onoff = '0;
    edge_wait(HD + 2);
    @(negedge clk); onoff = '1;
    for (int n = 1; n <= HD + 1; n++) begin
      @(posedge clk); #1;
      for (int i = 0; i < NCH; i++) e[i] = (i*STEP <= n-1);
      check($sformatf("R2 rise edge %0d", n), gate, e);
    end
    // R3 falling sweep
    @(negedge clk); onoff = '0;
    for (int n = 1; n <= HD + 1; n++) begin
      @(posedge clk); #1;
      for (int i = 0; i < NCH; i++) e[i] = !(i*STEP <= n-1);
      check($sformatf("R3 fall edge %0d", n), gate, e);
    end

    // R6: 3-cycle oe_n low pulse keeps its width on ch0 and ch15
    @(negedge clk); onoff = '1; oe_n = 1;
    edge_wait(HD + 2);
    @(negedge clk); oe_n = 0;
    cnt0 = 0; cnt15 = 0;
    for (int n = 0; n < HD + 8; n++) begin
      @(posedge clk); #1;
      if (n == 2) begin @(negedge clk); oe_n = 1; end
      cnt0 += gate[0]; cnt15 += gate[NCH-1];
    end
    check("R6 ch0 pulse width", NCH'(cnt0), NCH'(3));
    check("R6 ch15 pulse width", NCH'(cnt15), NCH'(3));

    // R7: kill acts within the cycle; R8: staggered restart
    @(negedge clk); oe_n = 0;
    edge_wait(HD + 2);
    check("R5 all on before kill", gate, '1);
    @(negedge clk); kill = 1;
    #1 check("R7 kill mid-cycle", gate, '0);
    edge_wait(2);
    @(negedge clk); kill = 0;
    #1 check("R8 dark at release", gate, '0);
    @(posedge clk); #1;
    check("R8 ch0 first after release", gate, NCH'(1));
    edge_wait(STEP);
    check("R8 ch1 one step later", gate, NCH'(3));

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: gate=%h expected=done", gate);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule